// File: doc/BRIEF.md
# Mode-Configurable Output Slice for a Programmable Logic Array

This block is one output slice of a small sum-of-products logic device. It takes the product-term results that an AND array produces for its column, and drops any terms marked as disabled. It ORs the rest, applies a programmable output polarity and can hold the result in a clocked register. It then drives a three-state pin and returns a feedback value to the array.

Two global bits pick one of three operating styles for every slice in the device. In the simple style the slices are plain combinational outputs or dedicated inputs. The complex style gives combinational outputs with a product-term enable. The registered style uses a shared clock and a shared active-low enable. Two per-slice bits pick the polarity and whether the slice is an output or an input/combinational slice. Two parameters describe where the slice sits in the row: an outermost slice, or one of the two centre slices. Those positions lose feedback in some styles.

Top module: `pld_out_cell`

## Requirements
- R1: The style is decoded from `modeSync` and `modeArch`. `modeArch`=0 selects simple, whatever the value of `modeSync`. `modeArch`=1 with `modeSync`=1 selects complex, and `modeArch`=1 with `modeSync`=0 selects registered.
- R2: A term whose bit in `termDisable` is 1 counts as logic 0 wherever it is used, both in the OR and as the term-0 output enable.
- R3: With `cellPolarity`=1 the pin level equals the OR result. With `cellPolarity`=0 it is the complement. This holds in all three styles; in a registered slice the pin level follows one clock later.
- R4: In the registered style with `cellIoSel`=0, the OR of all NTERMS terms is captured at each rising clock edge. `pinEnable` equals the inverse of `oeBarIn`, and `fbOut` equals the register content, which is always the inverse of `pinDrive`. The register captures on every edge in every style.
- R5: Asynchronous reset (`rstN`=0) clears the register at once, so that a registered slice drives `pinDrive`=1 whatever the polarity.
- R6: When `preloadEn`=1 at a rising edge, `preloadVal` is loaded into the register instead of the term result. After that edge `fbOut`=`preloadVal` and `pinDrive`=inverse of `preloadVal`.
- R7: A combinational slice in the registered style (`cellIoSel`=1), and every slice in the complex style, take `pinEnable` from term 0. They OR terms 1 to NTERMS-1 for the data, and `fbOut` equals `pinIn`.
- R8: In the complex style `cellIoSel` has no effect. An outermost slice (IS_OUTER=1) has `fbOut`=0 in that style.
- R9: A simple-style output slice (`cellIoSel`=0) has `pinEnable`=1 and ORs all NTERMS terms. Its `fbOut` equals `adjPinIn`, the pin of the adjacent slice.
- R10: A simple-style slice with `cellIoSel`=1 is a dedicated input: `pinEnable`=0, `pinDrive`=0, and `fbOut` equals `adjPinIn`.
- R11: A centre slice (IS_CENTER=1) in the simple style is always an enabled output with all NTERMS terms, and `cellIoSel` is ignored. Its `fbOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| termIn | input | NTERMS | Product-term results for this slice; bit 0 is the term that may serve as output enable |
| termDisable | input | NTERMS | Per-term disable, 1 forces that term to 0 |
| modeSync | input | 1 | Global style bit (0 with modeArch=1 means registered) |
| modeArch | input | 1 | Global style bit (0 means simple) |
| cellPolarity | input | 1 | 1 active-high, 0 active-low |
| cellIoSel | input | 1 | Per-slice configuration bit: 0 output/registered, 1 input or combinational I/O |
| oeBarIn | input | 1 | Shared active-low output enable for registered slices |
| pinIn | input | 1 | Level present on this slice's pin |
| adjPinIn | input | 1 | Level present on the adjacent slice's pin |
| preloadEn | input | 1 | Synchronous register force |
| preloadVal | input | 1 | Value forced into the register |
| pinDrive | output | 1 | Level driven onto the pin |
| pinEnable | output | 1 | Pin driver enable, 1 drives |
| fbOut | output | 1 | Feedback value returned to the AND array |

## Verification
A preload and a normal term capture can meet at the same clock edge. The bench drives `preloadEn` together with a term pattern whose own capture would store the opposite value, so the two cases give different pin levels. It then compares `fbOut` and `pinDrive` after that edge with the preload value rather than the term result. A further collision is an asynchronous reset while the register holds a 1. The pin is sampled within the same cycle and must already read high.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [1:0] {
    STYLE_SIMPLE     = 2'd0,
    STYLE_COMPLEX    = 2'd1,
    STYLE_REGISTERED = 2'd2
  } cellStyle_e;

  typedef enum logic [1:0] {
    OE_NEVER  = 2'd0,
    OE_ALWAYS = 2'd1,
    OE_SHARED = 2'd2,
    OE_TERM   = 2'd3
  } oeSel_e;

  typedef enum logic [1:0] {
    FB_NONE = 2'd0,
    FB_REG  = 2'd1,
    FB_PIN  = 2'd2,
    FB_ADJ  = 2'd3
  } fbSel_e;

  // Strobes from the decode to the datapath
  typedef struct packed {
    logic   useRegister;  // pin comes from the register
    logic   splitTerm;    // term 0 reserved for enable
    logic   driveLevel;   // pin data is meaningful
    oeSel_e oeSel;
    fbSel_e fbSel;
  } cellCtrl_t;

endpackage

// File: rtl/pld_cell_ctrl.sv
module pld_cell_ctrl
  import pld_cell_pkg::*;
#(
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTER = 1'b0
) (
  input  logic      modeSync,
  input  logic      modeArch,
  input  logic      cellIoSel,
  output cellCtrl_t ctrl
);

  cellStyle_e style;
  fbSel_e     complexFb;
  fbSel_e     simpleFb;
  logic       simpleIsOutput;

  // Position-dependent routing chosen at elaboration
  generate
    if (IS_OUTER) begin : g_outer
      assign complexFb = FB_NONE;
    end else begin : g_inner
      assign complexFb = FB_PIN;
    end
    if (IS_CENTER) begin : g_center
      assign simpleFb       = FB_NONE;
      assign simpleIsOutput = 1'b1;
    end else begin : g_side
      assign simpleFb       = FB_ADJ;
      assign simpleIsOutput = ~cellIoSel;
    end
  endgenerate

  always_comb begin
    if (!modeArch)     style = STYLE_SIMPLE;
    else if (modeSync) style = STYLE_COMPLEX;
    else               style = STYLE_REGISTERED;
  end

  always_comb begin
    ctrl.useRegister = 1'b0;
    ctrl.splitTerm   = 1'b0;
    ctrl.driveLevel  = 1'b1;
    ctrl.oeSel       = OE_ALWAYS;
    ctrl.fbSel       = FB_NONE;
    unique case (style)
      STYLE_REGISTERED: begin
        if (!cellIoSel) begin
          ctrl.useRegister = 1'b1;
          ctrl.oeSel       = OE_SHARED;
          ctrl.fbSel       = FB_REG;
        end else begin
          ctrl.splitTerm = 1'b1;
          ctrl.oeSel     = OE_TERM;
          ctrl.fbSel     = FB_PIN;
        end
      end
      STYLE_COMPLEX: begin
        ctrl.splitTerm = 1'b1;
        ctrl.oeSel     = OE_TERM;
        ctrl.fbSel     = complexFb;
      end
      default: begin
        ctrl.fbSel      = simpleFb;
        ctrl.driveLevel = simpleIsOutput;
        ctrl.oeSel      = simpleIsOutput ? OE_ALWAYS : OE_NEVER;
      end
    endcase
  end

endmodule

// File: rtl/pld_cell_datapath.sv
module pld_cell_datapath
  import pld_cell_pkg::*;
#(
  parameter int NTERMS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NTERMS-1:0] termIn,
  input  logic [NTERMS-1:0] termDisable,
  input  logic              cellPolarity,
  input  logic              oeBarIn,
  input  logic              pinIn,
  input  logic              adjPinIn,
  input  logic              preloadEn,
  input  logic              preloadVal,
  input  cellCtrl_t         ctrl,
  output logic              pinDrive,
  output logic              pinEnable,
  output logic              fbOut
);

  localparam int TAIL_LO = 1;

  logic [NTERMS-1:0] liveTerm;
  logic              sumAll;
  logic              sumTail;
  logic              oeTerm;
  logic              combSum;
  logic              combLevel;
  logic              captureBit;
  logic              regState;

  assign liveTerm  = termIn & ~termDisable;
  assign sumAll    = |liveTerm;
  assign sumTail   = |liveTerm[NTERMS-1:TAIL_LO];
  assign oeTerm    = liveTerm[0];
  assign combSum   = ctrl.splitTerm ? sumTail : sumAll;
  assign combLevel = cellPolarity ? combSum : ~combSum;

  // Register holds the complement of the pin level it will present
  assign captureBit = preloadEn ? preloadVal : ~(cellPolarity ? sumAll : ~sumAll);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regState <= 1'b0;
    else       regState <= captureBit;
  end

  always_comb begin
    if (ctrl.useRegister)     pinDrive = ~regState;
    else if (ctrl.driveLevel) pinDrive = combLevel;
    else                      pinDrive = 1'b0;
  end

  always_comb begin
    unique case (ctrl.oeSel)
      OE_NEVER:  pinEnable = 1'b0;
      OE_ALWAYS: pinEnable = 1'b1;
      OE_SHARED: pinEnable = ~oeBarIn;
      default:   pinEnable = oeTerm;
    endcase
  end

  always_comb begin
    unique case (ctrl.fbSel)
      FB_REG:  fbOut = regState;
      FB_PIN:  fbOut = pinIn;
      FB_ADJ:  fbOut = adjPinIn;
      default: fbOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NTERMS    = 8,
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTER = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NTERMS-1:0] termIn,
  input  logic [NTERMS-1:0] termDisable,
  input  logic              modeSync,
  input  logic              modeArch,
  input  logic              cellPolarity,
  input  logic              cellIoSel,
  input  logic              oeBarIn,
  input  logic              pinIn,
  input  logic              adjPinIn,
  input  logic              preloadEn,
  input  logic              preloadVal,
  output logic              pinDrive,
  output logic              pinEnable,
  output logic              fbOut
);

  cellCtrl_t ctrl;

  pld_cell_ctrl #(
    .IS_OUTER (IS_OUTER),
    .IS_CENTER(IS_CENTER)
  ) u_ctrl (
    .modeSync (modeSync),
    .modeArch (modeArch),
    .cellIoSel(cellIoSel),
    .ctrl     (ctrl)
  );

  pld_cell_datapath #(
    .NTERMS(NTERMS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .termIn      (termIn),
    .termDisable (termDisable),
    .cellPolarity(cellPolarity),
    .oeBarIn     (oeBarIn),
    .pinIn       (pinIn),
    .adjPinIn    (adjPinIn),
    .preloadEn   (preloadEn),
    .preloadVal  (preloadVal),
    .ctrl        (ctrl),
    .pinDrive    (pinDrive),
    .pinEnable   (pinEnable),
    .fbOut       (fbOut)
  );

endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int NTERMS    = 8,
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTER = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [NTERMS-1:0] termDisable,
  input logic              modeSync,
  input logic              modeArch,
  input logic              cellPolarity,
  input logic              cellIoSel,
  input logic              oeBarIn,
  input logic              adjPinIn,
  input logic              preloadEn,
  input logic              preloadVal,
  input logic              pinDrive,
  input logic              pinEnable,
  input logic              fbOut
);

  logic regSlice;
  assign regSlice = modeArch && !modeSync && !cellIoSel;

  p_simple_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeArch && !cellIoSel) |-> pinEnable);

  p_shared_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    regSlice |-> (pinEnable == !oeBarIn && fbOut == !pinDrive));

  p_preload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (preloadEn && regSlice) |=> (!regSlice || fbOut == $past(preloadVal)));

  p_disabled_terms_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeArch && !cellIoSel && (&termDisable)) |-> (pinDrive == !cellPolarity));

  p_dedicated_input_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!IS_CENTER && !modeArch && cellIoSel) |-> (!pinEnable && !pinDrive && fbOut == adjPinIn));

  p_outer_fb_r8: assert property (@(posedge clk) disable iff (!rstN)
    (IS_OUTER && modeArch && modeSync) |-> !fbOut);

endmodule

bind pld_out_cell pld_out_cell_chk #(
  .NTERMS(NTERMS), .IS_OUTER(IS_OUTER), .IS_CENTER(IS_CENTER)
) u_chk (
  .clk(clk), .rstN(rstN), .termDisable(termDisable), .modeSync(modeSync),
  .modeArch(modeArch), .cellPolarity(cellPolarity), .cellIoSel(cellIoSel),
  .oeBarIn(oeBarIn), .adjPinIn(adjPinIn), .preloadEn(preloadEn),
  .preloadVal(preloadVal), .pinDrive(pinDrive), .pinEnable(pinEnable), .fbOut(fbOut)
);

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;

  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] termIn = '0;
  logic [NT-1:0] termDisable = '0;
  logic          modeSync = 1'b0;
  logic          modeArch = 1'b1;
  logic          cellPolarity = 1'b0;
  logic          cellIoSel = 1'b0;
  logic          oeBarIn = 1'b0;
  logic          pinIn = 1'b0;
  logic          adjPinIn = 1'b0;
  logic          preloadEn = 1'b0;
  logic          preloadVal = 1'b0;
  logic [2:0]    outMain, outOuter, outCenter;  // {pinDrive,pinEnable,fbOut}

  int checks = 0;
  int fails = 0;
  logic modelQ = 1'b0;

  typedef struct {
    logic [2:0] expMain;
    logic [2:0] expOuter;
    logic [2:0] expCenter;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  pld_out_cell #(.NTERMS(NT)) uut (
    .clk(clk), .rstN(rstN), .termIn(termIn), .termDisable(termDisable),
    .modeSync(modeSync), .modeArch(modeArch), .cellPolarity(cellPolarity),
    .cellIoSel(cellIoSel), .oeBarIn(oeBarIn), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .preloadEn(preloadEn), .preloadVal(preloadVal),
    .pinDrive(outMain[2]), .pinEnable(outMain[1]), .fbOut(outMain[0]));

  pld_out_cell #(.NTERMS(NT), .IS_OUTER(1'b1)) uutOuter (
    .clk(clk), .rstN(rstN), .termIn(termIn), .termDisable(termDisable),
    .modeSync(modeSync), .modeArch(modeArch), .cellPolarity(cellPolarity),
    .cellIoSel(cellIoSel), .oeBarIn(oeBarIn), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .preloadEn(preloadEn), .preloadVal(preloadVal),
    .pinDrive(outOuter[2]), .pinEnable(outOuter[1]), .fbOut(outOuter[0]));

  pld_out_cell #(.NTERMS(NT), .IS_CENTER(1'b1)) uutCenter (
    .clk(clk), .rstN(rstN), .termIn(termIn), .termDisable(termDisable),
    .modeSync(modeSync), .modeArch(modeArch), .cellPolarity(cellPolarity),
    .cellIoSel(cellIoSel), .oeBarIn(oeBarIn), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .preloadEn(preloadEn), .preloadVal(preloadVal),
    .pinDrive(outCenter[2]), .pinEnable(outCenter[1]), .fbOut(outCenter[0]));

  // Expected {pinDrive,pinEnable,fbOut}; pos 0 plain, 1 outermost, 2 centre
  function automatic logic [2:0] predict(int pos, logic q);
    logic [NT-1:0] live;
    logic all, tail, lvlAll, lvlTail;
    live    = termIn & ~termDisable;
    all     = |live;
    tail    = |live[NT-1:1];
    lvlAll  = cellPolarity ? all : ~all;
    lvlTail = cellPolarity ? tail : ~tail;
    if (!modeArch) begin                         // R1 simple
      if (pos == 2)        return {lvlAll, 1'b1, 1'b0};      // R11
      else if (!cellIoSel) return {lvlAll, 1'b1, adjPinIn};  // R9
      else                 return {1'b0, 1'b0, adjPinIn};    // R10
    end else if (modeSync) begin                 // R1 complex, R7, R8
      return {lvlTail, live[0], (pos == 1) ? 1'b0 : pinIn};
    end else if (!cellIoSel) begin               // R4 registered
      return {~q, ~oeBarIn, q};
    end else begin                               // R7
      return {lvlTail, live[0], pinIn};
    end
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic compare(string who, string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, who, got, exp);
    end
  endtask

  task automatic step(logic syn, logic ac0, logic pol, logic ioSel, logic oeBar,
                      logic [NT-1:0] tIn, logic [NT-1:0] tDis, logic pIn, logic adj,
                      logic pre, logic preV, string tag);
    item_t it;
    logic live;
    @(negedge clk);
    modeSync = syn; modeArch = ac0; cellPolarity = pol; cellIoSel = ioSel;
    oeBarIn = oeBar; termIn = tIn; termDisable = tDis; pinIn = pIn;
    adjPinIn = adj; preloadEn = pre; preloadVal = preV;
    // Register keeps the complement of the pin level it presents (R4, R6)
    live = |(tIn & ~tDis);
    modelQ = pre ? preV : ~(pol ? live : ~live);
    it.expMain   = predict(0, modelQ);
    it.expOuter  = predict(1, modelQ);
    it.expCenter = predict(2, modelQ);
    it.tag       = tag;
    sbq.push_back(it);
  endtask

  // Monitor: sample 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        compare("plain",  it.tag, outMain,   it.expMain);
        compare("outer",  it.tag, outOuter,  it.expOuter);
        compare("centre", it.tag, outCenter, it.expCenter);
      end
    end
  end

  initial begin
    #(20 * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R5: reset state, registered slice, both polarities
    #3;
    compare("plain", "R5 reset pol0", outMain, 3'b110);
    cellPolarity = 1'b1;
    #1;
    compare("plain", "R5 reset pol1", outMain, 3'b110);
    @(negedge clk);
    rstN = 1'b1;

    // Registered style, registered slice
    step(0, 1, 1, 0, 0, 8'h80, 8'h00, 0, 0, 0, 0, "R4 capture high");
    step(0, 1, 1, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R4 capture low");
    step(0, 1, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R3 active-low reg");
    step(0, 1, 0, 0, 1, 8'h00, 8'h00, 0, 0, 0, 0, "R4 shared enable off");
    step(0, 1, 1, 0, 0, 8'h80, 8'h00, 0, 0, 1, 1, "R6 preload one beats terms");
    step(0, 1, 1, 0, 0, 8'h00, 8'h00, 0, 0, 1, 0, "R6 preload zero beats terms");
    step(0, 1, 1, 0, 0, 8'h01, 8'h01, 0, 0, 0, 0, "R2 disabled term in register");

    // R5: asynchronous reset while register holds 1
    @(negedge clk);
    #2;
    rstN = 1'b0;
    #2;
    compare("plain", "R5 async reset", outMain, 3'b110);
    modelQ = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // Registered style, combinational I/O slice
    step(0, 1, 1, 1, 0, 8'h03, 8'h00, 1, 0, 0, 0, "R7 term0 enable");
    step(0, 1, 1, 1, 0, 8'h01, 8'h00, 0, 0, 0, 0, "R7 tail excludes term0");
    step(0, 1, 0, 1, 0, 8'h02, 8'h00, 1, 0, 0, 0, "R7 R3 active-low comb");
    step(0, 1, 1, 1, 0, 8'h03, 8'h01, 1, 0, 0, 0, "R2 disabled enable term");

    // Complex style
    step(1, 1, 1, 1, 0, 8'h81, 8'h00, 1, 0, 0, 0, "R1 R8 complex");
    step(1, 1, 0, 0, 0, 8'h81, 8'h00, 1, 0, 0, 0, "R8 io bit ignored");

    // Simple style
    step(1, 0, 1, 0, 0, 8'h01, 8'h00, 0, 1, 0, 0, "R1 R9 simple output");
    step(0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R1 R9 simple with sync low");
    step(1, 0, 0, 1, 0, 8'h00, 8'h00, 0, 1, 0, 0, "R10 R11 dedicated input");
    step(1, 0, 1, 0, 0, 8'hFF, 8'hFF, 1, 0, 0, 0, "R2 all disabled simple");
    step(1, 0, 1, 0, 0, 8'h80, 8'h00, 0, 0, 0, 0, "R4 register captures in simple");

    // Back to registered: register content from previous edge is visible
    step(0, 1, 0, 0, 0, 8'h04, 8'h00, 0, 0, 0, 0, "R4 return to registered");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule